// File: doc/BRIEF.md
# Banked Forwarding Register File

This block is a 127-entry, 64-bit register file for one operand class, either integer or floating point. Storage is split into four 32-bit banks. A register's number parity and its upper or lower half pick the bank. Each bank has one write port and two read ports. Several writers can therefore retire in the same cycle:

- two full 64-bit results, one to an odd register and one to an even register; or
- four 32-bit results that each land in a different parity/half bank.

Every write carries per-byte enables. A byte or halfword update changes only the selected bytes and needs no read beforehand.

The read ports are combinational. A read whose address matches a write accepted in the same cycle returns the stored word with the newly written bytes merged in, so the file doubles as an operand forwarding path.

The write side uses valid plus refusal rather than a ready signal. A write is offered by raising its valid for one cycle. When a lower-numbered port already claims a bank the write needs, the whole write is refused and the port's conflict flag goes high in that same cycle. The refused write has no effect, and the requester retries later. A write to register 127, or one with no byte enabled, claims no bank and is never refused. Reads are never refused.

Top module: `rf_banked`

## Requirements
- R1: Reset (synchronous, `rst_n` low at a rising edge) clears every register, so every read afterwards returns zero until written.
- R2: A write accepted on a rising edge is visible on any read port from that edge on, and stays until overwritten.
- R3: Write byte enable bit k (0 = least significant) covers data bits 8k+7..8k; bytes whose enable is low keep their old value.
- R4: Two full-width writes to one odd and one even register in the same cycle are both accepted and stored.
- R5: Four writes in one cycle are all accepted when each one's enabled bytes fall in a distinct bank. Bank = (half, parity), where half 0 is enable bits 3..0, half 1 is enable bits 7..4, and parity is address bit 0.
- R6: A read of a register being written by accepted writes in the same cycle returns the stored value, with the enabled bytes of those writes substituted combinationally. Bytes of refused writes are not forwarded.
- R7: Register number 127 is outside the file: a write to it changes nothing and claims no bank, and a read of it returns zero.
- R8: When two valid writes in one cycle need the same bank, the lower-numbered port wins. The higher port's whole write is dropped and its `wr_conflict` bit is high in that cycle. Port 0 is never refused.
- R9: `wr_conflict[i]` is high only when port i is valid, addresses a register below 127, has at least one enabled byte, and shares a bank with a lower valid port. A valid write with all enables low changes nothing and claims no bank.
- R10: The two read ports are independent: each returns its own address's value in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | NWP (4) | Per-port write request |
| wr_addr | input | NWP x 7 | Per-port destination register number |
| wr_be | input | NWP x 8 | Per-port byte enables, bit k covers byte k |
| wr_data | input | NWP x 64 | Per-port write data |
| wr_conflict | output | NWP (4) | Per-port refusal flag for a bank clash, same cycle |
| rd_addr | input | NRP (2) x 7 | Per-port read register number |
| rd_data | output | NRP (2) x 64 | Per-port read data, combinational with forwarding |

## Verification
Bank arbitration and read forwarding meet in the same cycle whenever a read address equals the destination of writes that compete for a bank. The stimulus sends two ports at one register's lower half, so the higher port is refused, while a read port watches that register. The merged read must show only the winner's bytes, the refused port's flag must be high, and the readback on the following cycles must show the refused bytes never landed. Partial forwarding, where only some bytes are enabled, is judged the same way against a byte-accurate reference model kept in the bench.

// File: rtl/rf_pkg.sv
`timescale 1ns/1ps
package rf_pkg;
  localparam int RF_XLEN   = 64;
  localparam int RF_HALF_W = 32;
  localparam int RF_NHALF  = RF_XLEN / RF_HALF_W;
  localparam int RF_NPAR   = 2;
  localparam int RF_NBANK  = RF_NHALF * RF_NPAR;
  localparam int RF_NREG   = 127;
  localparam int RF_AW     = $clog2(RF_NREG + 1);
  localparam int RF_IDXW   = RF_AW - 1;
  localparam int RF_DEPTH  = 1 << RF_IDXW;
  localparam int RF_BYTES  = RF_XLEN / 8;
  localparam int RF_HBYTES = RF_HALF_W / 8;
  localparam logic [RF_AW-1:0] RF_BAD_ADDR = RF_AW'(RF_NREG);

  // One bank's write command for a cycle
  typedef struct packed {
    logic                 en;
    logic [RF_IDXW-1:0]   idx;
    logic [RF_HALF_W-1:0] data;
    logic [RF_HBYTES-1:0] be;
  } bank_wr_t;
endpackage

// File: rtl/rf_bank.sv
`timescale 1ns/1ps
module rf_bank
  import rf_pkg::*;
#(
  parameter int NRP = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  bank_wr_t                           cmd,
  input  logic [NRP-1:0][RF_IDXW-1:0]        rd_idx,
  output logic [NRP-1:0][RF_HALF_W-1:0]      rd_word
);
  logic [RF_HALF_W-1:0] mem [RF_DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < RF_DEPTH; e++) mem[e] <= '0;
    end else if (cmd.en) begin
      for (int k = 0; k < RF_HBYTES; k++) begin
        if (cmd.be[k]) mem[cmd.idx][k*8 +: 8] <= cmd.data[k*8 +: 8];
      end
    end
  end

  for (genvar r = 0; r < NRP; r++) begin : g_rd
    assign rd_word[r] = mem[rd_idx[r]];
  end

  // A command that reaches a bank always enables at least one byte
  AST_BANK_CMD_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.en |-> (cmd.be != '0));  // R9
endmodule

// File: rtl/rf_wr_arbiter.sv
`timescale 1ns/1ps
module rf_wr_arbiter
  import rf_pkg::*;
#(
  parameter int NWP = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NWP-1:0]                    wr_valid,
  input  logic [NWP-1:0][RF_AW-1:0]         wr_addr,
  input  logic [NWP-1:0][RF_BYTES-1:0]      wr_be,
  input  logic [NWP-1:0][RF_XLEN-1:0]       wr_data,
  output logic [NWP-1:0]                    grant,
  output logic [NWP-1:0]                    conflict,
  output bank_wr_t [RF_NBANK-1:0]           bank_cmd
);
  logic [NWP-1:0][RF_NBANK-1:0] need;
  logic [NWP-1:0][RF_NBANK-1:0] below;
  logic [RF_NBANK-1:0][NWP-1:0] owner;
  logic [RF_NBANK-1:0]          acc;

  // Bank b = half * RF_NPAR + parity
  always_comb begin
    for (int i = 0; i < NWP; i++) begin
      for (int b = 0; b < RF_NBANK; b++) begin
        need[i][b] = wr_valid[i] && (wr_addr[i] != RF_BAD_ADDR)
                  && (wr_addr[i][0] == 1'(b % RF_NPAR))
                  && (|wr_be[i][(b / RF_NPAR)*RF_HBYTES +: RF_HBYTES]);
      end
    end
    acc = '0;
    for (int i = 0; i < NWP; i++) begin
      below[i]    = acc;
      acc         = acc | need[i];
      conflict[i] = |(need[i] & below[i]);
      grant[i]    = (|need[i]) && !conflict[i];
    end
  end

  always_comb begin
    for (int b = 0; b < RF_NBANK; b++) begin
      bank_cmd[b] = '0;
      for (int i = NWP - 1; i >= 0; i--) begin
        owner[b][i] = grant[i] && need[i][b];
        if (owner[b][i]) begin
          bank_cmd[b].en   = 1'b1;
          bank_cmd[b].idx  = wr_addr[i][RF_AW-1:1];
          bank_cmd[b].data = wr_data[i][(b / RF_NPAR)*RF_HALF_W +: RF_HALF_W];
          bank_cmd[b].be   = wr_be[i][(b / RF_NPAR)*RF_HBYTES +: RF_HBYTES];
        end
      end
    end
  end

  for (genvar b = 0; b < RF_NBANK; b++) begin : g_chk
    AST_ONE_WRITER_PER_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(owner[b]));  // R8
  end
endmodule

// File: rtl/rf_fwd_read.sv
`timescale 1ns/1ps
module rf_fwd_read
  import rf_pkg::*;
#(
  parameter int NWP = 4
) (
  input  logic [RF_AW-1:0]                  rd_addr,
  input  logic [RF_NBANK-1:0][RF_HALF_W-1:0] bank_word,
  input  logic [NWP-1:0]                    grant,
  input  logic [NWP-1:0][RF_AW-1:0]         wr_addr,
  input  logic [NWP-1:0][RF_BYTES-1:0]      wr_be,
  input  logic [NWP-1:0][RF_XLEN-1:0]       wr_data,
  output logic [RF_XLEN-1:0]                rd_data
);
  logic [RF_XLEN-1:0] merged;

  always_comb begin
    for (int h = 0; h < RF_NHALF; h++) begin
      merged[h*RF_HALF_W +: RF_HALF_W] = bank_word[h*RF_NPAR + int'(rd_addr[0])];
    end
    for (int i = 0; i < NWP; i++) begin
      if (grant[i] && (wr_addr[i] == rd_addr)) begin
        for (int k = 0; k < RF_BYTES; k++) begin
          if (wr_be[i][k]) merged[k*8 +: 8] = wr_data[i][k*8 +: 8];
        end
      end
    end
    rd_data = (rd_addr == RF_BAD_ADDR) ? '0 : merged;
  end
endmodule

// File: rtl/rf_banked.sv
`timescale 1ns/1ps
module rf_banked
  import rf_pkg::*;
#(
  parameter int NWP = 4,
  parameter int NRP = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NWP-1:0]                wr_valid,
  input  logic [NWP-1:0][RF_AW-1:0]     wr_addr,
  input  logic [NWP-1:0][RF_BYTES-1:0]  wr_be,
  input  logic [NWP-1:0][RF_XLEN-1:0]   wr_data,
  output logic [NWP-1:0]                wr_conflict,
  input  logic [NRP-1:0][RF_AW-1:0]     rd_addr,
  output logic [NRP-1:0][RF_XLEN-1:0]   rd_data
);
  logic [NWP-1:0]                          grant;
  bank_wr_t [RF_NBANK-1:0]                 bank_cmd;
  logic [NRP-1:0][RF_IDXW-1:0]             rd_idx;
  logic [RF_NBANK-1:0][NRP-1:0][RF_HALF_W-1:0] bank_out;
  logic [NRP-1:0][RF_NBANK-1:0][RF_HALF_W-1:0] port_words;

  rf_wr_arbiter #(.NWP(NWP)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_be    (wr_be),
    .wr_data  (wr_data),
    .grant    (grant),
    .conflict (wr_conflict),
    .bank_cmd (bank_cmd)
  );

  for (genvar r = 0; r < NRP; r++) begin : g_idx
    assign rd_idx[r] = rd_addr[r][RF_AW-1:1];
  end

  for (genvar b = 0; b < RF_NBANK; b++) begin : g_bank
    rf_bank #(.NRP(NRP)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd     (bank_cmd[b]),
      .rd_idx  (rd_idx),
      .rd_word (bank_out[b])
    );
    for (genvar r = 0; r < NRP; r++) begin : g_x
      assign port_words[r][b] = bank_out[b][r];
    end
  end

  for (genvar r = 0; r < NRP; r++) begin : g_rd
    rf_fwd_read #(.NWP(NWP)) u_rd (
      .rd_addr   (rd_addr[r]),
      .bank_word (port_words[r]),
      .grant     (grant),
      .wr_addr   (wr_addr),
      .wr_be     (wr_be),
      .wr_data   (wr_data),
      .rd_data   (rd_data[r])
    );
  end

  // Marks cycles whose previous cycle already followed a reset
  logic rst_seen, past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_seen <= 1'b1;
      past_ok  <= 1'b0;
    end else begin
      past_ok  <= rst_seen;
    end
  end

  AST_PORT0_NEVER_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_conflict[0]);  // R8
  AST_FULL_WRITE_FORWARDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid[0] && (wr_be[0] == '1) && (wr_addr[0] != RF_BAD_ADDR)
     && (rd_addr[0] == wr_addr[0])) |-> (rd_data[0] == wr_data[0]));  // R6

  for (genvar i = 0; i < NWP; i++) begin : g_wchk
    AST_CONFLICT_NEEDS_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
      wr_conflict[i] |-> (wr_valid[i] && (wr_be[i] != '0) && (wr_addr[i] != RF_BAD_ADDR)));  // R9
  end

  for (genvar r = 0; r < NRP; r++) begin : g_rchk
    AST_TOP_REG_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr[r] == RF_BAD_ADDR) |-> (rd_data[r] == '0));  // R7
    AST_IDLE_READ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && ($past(wr_valid) == '0) && (wr_valid == '0) && $stable(rd_addr[r]))
      |-> $stable(rd_data[r]));  // R2
  end
endmodule

// File: tb/sim_rf_banked.sv
`timescale 1ns/1ps
module sim_rf_banked;
  import rf_pkg::*;
  localparam int NWP = 4;
  localparam int NRP = 2;
  localparam int NV  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [NWP-1:0]                 wr_valid;
  logic [NWP-1:0][RF_AW-1:0]      wr_addr;
  logic [NWP-1:0][RF_BYTES-1:0]   wr_be;
  logic [NWP-1:0][RF_XLEN-1:0]    wr_data;
  logic [NWP-1:0]                 wr_conflict;
  logic [NRP-1:0][RF_AW-1:0]      rd_addr;
  logic [NRP-1:0][RF_XLEN-1:0]    rd_data;

  rf_banked #(.NWP(NWP), .NRP(NRP)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_be(wr_be), .wr_data(wr_data), .wr_conflict(wr_conflict),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  typedef struct packed {
    logic [3:0]       v;
    logic [3:0][6:0]  a;
    logic [3:0][7:0]  be;
    logic [3:0][63:0] d;
    logic [6:0]       r0;
    logic [6:0]       r1;
    logic [3:0]       conf;
  } vec_t;

  localparam logic [6:0]  Z7  = 7'd0;
  localparam logic [7:0]  Z8  = 8'd0;
  localparam logic [63:0] Z64 = 64'd0;

  // Ports listed 3,2,1,0 inside each field
  localparam vec_t VECS [NV] = '{
    '{4'b0001, {Z7,Z7,Z7,7'd4}, {Z8,Z8,Z8,8'hFF},
      {Z64,Z64,Z64,64'h1111_2222_3333_4444}, 7'd4, 7'd5, 4'b0000},
    '{4'b0011, {Z7,Z7,7'd7,7'd6}, {Z8,Z8,8'hFF,8'hFF},
      {Z64,Z64,64'h0123_4567_89AB_CDEF,64'hAAAA_BBBB_CCCC_DDDD}, 7'd6, 7'd7, 4'b0000},
    '{4'b1111, {7'd9,7'd9,7'd8,7'd8}, {8'hF0,8'h0F,8'hF0,8'h0F},
      {64'h9090_9090_0000_0000,64'h0000_0000_9999_0009,
       64'h8080_8080_0000_0000,64'h0000_0000_8888_0008}, 7'd8, 7'd9, 4'b0000},
    '{4'b0001, {Z7,Z7,Z7,7'd4}, {Z8,Z8,Z8,8'h05},
      {Z64,Z64,Z64,64'hFFFF_FFFF_FFEE_FFDD}, 7'd4, 7'd6, 4'b0000},
    '{4'b0011, {Z7,Z7,7'd12,7'd10}, {Z8,Z8,8'hFF,8'hFF},
      {Z64,Z64,64'h1212_1212_1212_1212,64'h1010_1010_1010_1010}, 7'd10, 7'd12, 4'b0010},
    '{4'b1111, {7'd2,7'd15,7'd13,7'd11}, {8'hFF,8'h01,8'hF0,8'h0F},
      {64'h0202_0202_0202_0202,64'h0000_0000_0000_0015,
       64'h1313_1313_0000_0000,64'h0000_0000_1111_1111}, 7'd15, 7'd13, 4'b0100},
    '{4'b0011, {Z7,Z7,7'd1,7'd127}, {Z8,Z8,8'h0F,8'hFF},
      {Z64,Z64,64'h0000_0000_0101_0101,64'h7F7F_7F7F_7F7F_7F7F}, 7'd127, 7'd1, 4'b0000},
    '{4'b0011, {Z7,Z7,7'd22,7'd20}, {Z8,Z8,8'hFF,8'h00},
      {Z64,Z64,64'h2222_2222_2222_2222,64'h2020_2020_2020_2020}, 7'd20, 7'd22, 4'b0000},
    '{4'b0001, {Z7,Z7,Z7,7'd4}, {Z8,Z8,Z8,8'hC0},
      {Z64,Z64,Z64,64'h5A5A_0000_0000_0000}, 7'd4, 7'd6, 4'b0000},
    '{4'b0011, {Z7,Z7,7'd30,7'd30}, {Z8,Z8,8'h03,8'h0F},
      {Z64,Z64,64'hEEEE_EEEE_EEEE_EEEE,64'h0000_0000_3030_3030}, 7'd30, 7'd31, 4'b0010}
  };

  function automatic string tag_of(int i);
    case (i)
      0: return "R2";
      1: return "R4";
      2: return "R5";
      3: return "R3";
      4: return "R8";
      5: return "R8";
      6: return "R7";
      7: return "R9";
      default: return "R6";
    endcase
  endfunction

  int n_run = 0;
  int n_fail = 0;
  logic [63:0] model [128];

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_read(logic [6:0] ra, vec_t v, logic [3:0] gr);
    logic [63:0] w;
    if (ra == 7'd127) return 64'd0;
    w = model[ra];
    for (int i = 0; i < 4; i++) begin
      if (gr[i] && v.a[i] == ra) begin
        for (int k = 0; k < 8; k++) if (v.be[i][k]) w[k*8 +: 8] = v.d[i][k*8 +: 8];
      end
    end
    return w;
  endfunction

  task automatic drive_idle();
    wr_valid = '0; wr_addr = '0; wr_be = '0; wr_data = '0;
  endtask

  task automatic run_vec(vec_t v, string tag);
    logic [3:0] gr;
    @(negedge clk);
    wr_valid = v.v; wr_addr = v.a; wr_be = v.be; wr_data = v.d;
    rd_addr[0] = v.r0; rd_addr[1] = v.r1;
    gr = v.v & ~v.conf;
    for (int i = 0; i < 4; i++) if (v.a[i] == 7'd127 || v.be[i] == 8'd0) gr[i] = 1'b0;
    #1;
    chk(tag, "conflict flags", 64'(wr_conflict), 64'(v.conf));
    chk(tag, "read port 0", rd_data[0], exp_read(v.r0, v, gr));
    chk(tag, "read port 1", rd_data[1], exp_read(v.r1, v, gr));
    @(posedge clk);
    for (int i = 0; i < 4; i++) begin
      if (gr[i]) begin
        for (int k = 0; k < 8; k++)
          if (v.be[i][k]) model[v.a[i]][k*8 +: 8] = v.d[i][k*8 +: 8];
      end
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 128; a++) model[a] = 64'd0;
    drive_idle();
    rd_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    rd_addr[0] = 7'd0; rd_addr[1] = 7'd126;
    #1;
    // R1: reset state
    chk("R1", "read reg 0 after reset", rd_data[0], 64'd0);
    chk("R1", "read reg 126 after reset", rd_data[1], 64'd0);
    chk("R1", "no conflict after reset", 64'(wr_conflict), 64'd0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], tag_of(i));

    // R2 / R10: full readback with two independent read ports
    for (int a = 0; a < 128; a += 2) begin
      @(negedge clk);
      drive_idle();
      rd_addr[0] = 7'(a); rd_addr[1] = 7'(a + 1);
      #1;
      chk("R2", "readback even reg", rd_data[0], model[a]);
      chk("R10", "readback odd reg", rd_data[1], (a + 1 == 127) ? 64'd0 : model[a + 1]);
    end

    // R7: write to 127 then read it back
    @(negedge clk);
    wr_valid = 4'b0001; wr_addr[0] = 7'd127; wr_be[0] = 8'hFF; wr_data[0] = '1;
    rd_addr[0] = 7'd127; rd_addr[1] = 7'd126;
    #1;
    chk("R7", "same-cycle read of reg 127", rd_data[0], 64'd0);
    @(negedge clk);
    drive_idle();
    #1;
    chk("R7", "read of reg 127 after write", rd_data[0], 64'd0);
    chk("R7", "reg 126 untouched", rd_data[1], model[126]);

    // R1: second reset clears written registers
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd_addr[0] = 7'd4; rd_addr[1] = 7'd7;
    #1;
    chk("R1", "reg 4 cleared by reset", rd_data[0], 64'd0);
    chk("R1", "reg 7 cleared by reset", rd_data[1], 64'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule